// File: doc/BRIEF.md
# Masked Minimum Finder

This block looks at a set of N priority values, each W bits wide, and picks the smallest one. Only entries whose bit is set in an N-bit eligibility mask take part. It reports three things: the winning value, the position of that entry, and a flag that says whether any entry was eligible at all. Inside is a binary tree of N-1 two-input compare-and-select nodes, arranged in log2(N) levels. Each node passes up the smaller of its two candidates together with that candidate's index and a valid bit. An ineligible entry can therefore never win, and the mask may differ freely from one transfer to the next.

Whole sets of values enter on a valid/ready stream and results leave on a second valid/ready stream. A set is taken in on any rising edge where `in_valid` and `in_ready` are both high. A result is handed over on any edge where `out_valid` and `out_ready` are both high. The parameter PIPE sets the latency:

- PIPE=1 places one register stage after the tree. The result of an accepted set appears on the next cycle and is held for as long as the consumer stalls. `in_ready` is high when that stage is empty or is being emptied on the same edge.
- PIPE=0 passes the tree output straight through. In that case `out_valid` follows `in_valid` and `in_ready` follows `out_ready` in the same cycle.

N must be a power of two of at least 2.

Top module: `minq_top`

## Requirements
- R1: When at least one entry is eligible, `out_min` equals the smallest value among the entries whose mask bit is set. Entry i occupies bits [i*W +: W] of `in_vals` and is governed by bit i of `in_mask`.
- R2: `out_idx` is the index i of an eligible entry whose value equals `out_min`.
- R3: When several eligible entries share the minimum value, `out_idx` is the lowest of their indices.
- R4: An entry whose mask bit is 0 never wins, even when its value is smaller than every eligible value.
- R5: When `in_mask` is all zeros, `out_found` is 0. `out_min` and `out_idx` are then driven but carry no meaning.
- R6: Each accepted set is evaluated on its own. Back-to-back transfers with different masks and values each yield their own result, with nothing carried over from the previous set.
- R7: With PIPE=1, `out_valid` is 0 during and directly after reset. The result of a set accepted on one edge is presented with `out_valid`=1 after that edge. `out_valid` returns to 0 once the result has been taken and no new set was accepted.
- R8: With PIPE=1, while `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and `out_min`, `out_idx` and `out_found` stay unchanged. When `out_ready` rises, the held result is handed over and a waiting set is accepted on the same edge.
- R9: With PIPE=0, the outputs follow the inputs within the same cycle, `out_valid` equals `in_valid` and `in_ready` equals `out_ready`.
- R10: `out_found` is 1 whenever any mask bit is set, including when the only eligible value is all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A value set and mask are offered |
| in_ready | output | 1 | The block can take a set on this edge |
| in_vals | input | N*W | Entry i in bits [i*W +: W] |
| in_mask | input | N | Bit i set: entry i is eligible |
| out_valid | output | 1 | A result is presented |
| out_ready | input | 1 | The consumer takes the result on this edge |
| out_found | output | 1 | At least one entry was eligible |
| out_min | output | W | Smallest eligible value |
| out_idx | output | clog2(N) | Index of the winning entry |

## Verification
The hardest case to reach from the ports is a tie that has to be settled above the first level of the tree. Two equal minima must sit in different subtrees while a smaller, ineligible value sits elsewhere, so that the lower-index rule and the mask both act in nodes that no single leaf pair exercises. The vector table builds this on purpose with uniform value sets under sparse masks, and with a masked zero placed next to a lone all-ones winner. A stall is then held across an edge while the next set waits at the input, which shows that the registered result stays put and that the hand-over and the new acceptance happen together.

// File: rtl/minq_pkg.sv
package minq_pkg;

  // Index width for an N-entry tree, never below one bit.
  function automatic int idx_bits(input int n);
    int b;
    b = 1;
    while ((1 << b) < n) b++;
    return b;
  endfunction

endpackage

// File: rtl/minq_node.sv
module minq_node #(
  parameter int W    = 24,
  parameter int IDXW = 8
) (
  input  logic            a_vld,
  input  logic [W-1:0]    a_val,
  input  logic [IDXW-1:0] a_idx,
  input  logic            b_vld,
  input  logic [W-1:0]    b_val,
  input  logic [IDXW-1:0] b_idx,
  output logic            o_vld,
  output logic [W-1:0]    o_val,
  output logic [IDXW-1:0] o_idx
);

  logic pick_b;

  // The right (higher index) side wins only when it is valid and either the
  // left side is invalid or strictly larger; equality keeps the left side.
  always_comb begin
    pick_b = b_vld && (!a_vld || (b_val < a_val));
    o_vld  = a_vld | b_vld;
    o_val  = pick_b ? b_val : a_val;
    o_idx  = pick_b ? b_idx : a_idx;
  end

endmodule

// File: rtl/minq_tree.sv
module minq_tree #(
  parameter int N    = 256,
  parameter int W    = 24,
  parameter int IDXW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N*W-1:0]  vals,
  input  logic [N-1:0]    mask,
  output logic            root_vld,
  output logic [W-1:0]    root_val,
  output logic [IDXW-1:0] root_idx
);

  // Heap numbering: node 1 is the root, node k has children 2k and 2k+1,
  // leaves are N .. 2N-1.
  localparam int NODES = 2 * N;

  logic            h_vld [1:NODES-1];
  logic [W-1:0]    h_val [1:NODES-1];
  logic [IDXW-1:0] h_idx [1:NODES-1];

  for (genvar j = 0; j < N; j++) begin : g_leaf
    assign h_vld[N+j] = mask[j];
    assign h_val[N+j] = vals[j*W +: W];
    assign h_idx[N+j] = IDXW'(j);
  end

  for (genvar k = 1; k < N; k++) begin : g_node
    minq_node #(.W(W), .IDXW(IDXW)) u_node (
      .a_vld (h_vld[2*k]),
      .a_val (h_val[2*k]),
      .a_idx (h_idx[2*k]),
      .b_vld (h_vld[2*k+1]),
      .b_val (h_val[2*k+1]),
      .b_idx (h_idx[2*k+1]),
      .o_vld (h_vld[k]),
      .o_val (h_val[k]),
      .o_idx (h_idx[k])
    );
  end

  assign root_vld = h_vld[1];
  assign root_val = h_val[1];
  assign root_idx = h_idx[1];

  // Root result against each leaf, checked per entry.
  for (genvar j = 0; j < N; j++) begin : g_chk
    AST_MIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      mask[j] |-> (root_vld && root_val <= vals[j*W +: W])); // R1
    AST_TIE_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
      (mask[j] && vals[j*W +: W] == root_val) |-> (root_idx <= IDXW'(j))); // R3
  end

  AST_WINNER_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    root_vld |-> (mask[root_idx] && vals[root_idx*W +: W] == root_val)); // R2

  AST_NONE_FOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !root_vld |-> (mask == '0)); // R5

endmodule

// File: rtl/minq_outreg.sv
module minq_outreg #(
  parameter int W    = 24,
  parameter int IDXW = 8,
  parameter int PIPE = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            d_found,
  input  logic [W-1:0]    d_min,
  input  logic [IDXW-1:0] d_idx,
  output logic            out_valid,
  input  logic            out_ready,
  output logic            out_found,
  output logic [W-1:0]    out_min,
  output logic [IDXW-1:0] out_idx
);

  if (PIPE != 0) begin : g_reg
    logic            full_q;
    logic            found_q;
    logic [W-1:0]    min_q;
    logic [IDXW-1:0] idx_q;
    logic            take;

    assign in_ready = !full_q || out_ready;
    assign take     = in_valid && in_ready;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    full_q <= 1'b0;
      else if (take) full_q <= 1'b1;
      else if (out_ready) full_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (take) begin
        found_q <= d_found;
        min_q   <= d_min;
        idx_q   <= d_idx;
      end
    end

    assign out_valid = full_q;
    assign out_found = found_q;
    assign out_min   = min_q;
    assign out_idx   = idx_q;

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=>
        (out_valid && $stable(out_min) && $stable(out_idx) && $stable(out_found))); // R8
    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready); // R8
    AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid); // R7
  end else begin : g_pass
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_found = d_found;
    assign out_min   = d_min;
    assign out_idx   = d_idx;

    AST_PASS_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid == in_valid) && (in_ready == out_ready)); // R9
  end

endmodule

// File: rtl/minq_top.sv
module minq_top
  import minq_pkg::*;
#(
  parameter int N    = 256,
  parameter int W    = 24,
  parameter int PIPE = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [N*W-1:0]         in_vals,
  input  logic [N-1:0]           in_mask,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic                   out_found,
  output logic [W-1:0]           out_min,
  output logic [idx_bits(N)-1:0] out_idx
);

  localparam int IDXW = idx_bits(N);

  logic            t_vld;
  logic [W-1:0]    t_val;
  logic [IDXW-1:0] t_idx;

  minq_tree #(.N(N), .W(W), .IDXW(IDXW)) u_tree (
    .clk      (clk),
    .rst_n    (rst_n),
    .vals     (in_vals),
    .mask     (in_mask),
    .root_vld (t_vld),
    .root_val (t_val),
    .root_idx (t_idx)
  );

  minq_outreg #(.W(W), .IDXW(IDXW), .PIPE(PIPE)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .d_found   (t_vld),
    .d_min     (t_val),
    .d_idx     (t_idx),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_found (out_found),
    .out_min   (out_min),
    .out_idx   (out_idx)
  );

endmodule

// File: tb/sim_minq_top.sv
`timescale 1ns/1ps
module sim_minq_top;

  localparam int N = 8;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic           in_valid = 1'b0;
  logic           out_ready = 1'b0;
  logic [N*W-1:0] in_vals = '0;
  logic [N-1:0]   in_mask = '0;

  logic           q_in_ready, q_out_valid, q_found;
  logic [W-1:0]   q_min;
  logic [2:0]     q_idx;
  logic           c_in_ready, c_out_valid, c_found;
  logic [W-1:0]   c_min;
  logic [2:0]     c_idx;

  minq_top #(.N(N), .W(W), .PIPE(1)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(q_in_ready),
    .in_vals(in_vals), .in_mask(in_mask), .out_valid(q_out_valid),
    .out_ready(out_ready), .out_found(q_found), .out_min(q_min), .out_idx(q_idx)
  );

  minq_top #(.N(N), .W(W), .PIPE(0)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(c_in_ready),
    .in_vals(in_vals), .in_mask(in_mask), .out_valid(c_out_valid),
    .out_ready(out_ready), .out_found(c_found), .out_min(c_min), .out_idx(c_idx)
  );

  // {mask[83:76], values e7..e0 [75:12], found[11], min[10:3], idx[2:0]}
  localparam logic [83:0] VEC [0:7] = '{
    {8'hFF, 64'h50463C0A141E2832, 1'b1, 8'h0A, 3'd4},  // R1 R2 plain minimum
    {8'hEF, 64'h50463C0A141E2832, 1'b1, 8'h14, 3'd3},  // R4 winner masked off
    {8'hFF, 64'h0707070707070707, 1'b1, 8'h07, 3'd0},  // R3 all equal
    {8'hA0, 64'h0707070707070707, 1'b1, 8'h07, 3'd5},  // R3 tie across subtrees
    {8'h00, 64'h0102030405060708, 1'b0, 8'h00, 3'd0},  // R5 nothing eligible
    {8'h80, 64'hFFFFFFFFFFFFFF00, 1'b1, 8'hFF, 3'd7},  // R10 R4 lone all-ones
    {8'hFF, 64'h0102020202020202, 1'b1, 8'h01, 3'd7},  // R1 rightmost wins
    {8'h01, 64'h0000000000000099, 1'b1, 8'h99, 3'd0}   // R4 single leftmost
  };

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input int k);
    in_mask = VEC[k][83:76];
    in_vals = VEC[k][75:12];
  endtask

  task automatic chk_vec(input string tag, input int k, input logic f,
                         input logic [W-1:0] m, input logic [2:0] i);
    chk({tag, " R5 R10 found"}, 32'(f), 32'(VEC[k][11]));
    if (VEC[k][11]) begin
      chk({tag, " R1 R4 min"}, 32'(m), 32'(VEC[k][10:3]));
      chk({tag, " R2 R3 idx"}, 32'(i), 32'(VEC[k][2:0]));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R7 reset out_valid", 32'(q_out_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 idle after reset", 32'(q_out_valid), 32'd0);

    // Streaming walk, back-to-back (R6).
    drive(0);
    in_valid  = 1'b1;
    out_ready = 1'b1;
    for (int k = 0; k < 8; k++) begin
      #1;
      chk("R9 comb valid", 32'(c_out_valid), 32'd1);
      chk_vec("R9 comb", k, c_found, c_min, c_idx);
      @(negedge clk);
      chk("R7 R6 out_valid", 32'(q_out_valid), 32'd1);
      chk_vec("R6 piped", k, q_found, q_min, q_idx);
      if (k < 7) drive(k + 1);
      else in_valid = 1'b0;
    end
    @(negedge clk);
    chk("R7 drained", 32'(q_out_valid), 32'd0);
    chk("R9 comb follows in_valid", 32'(c_out_valid), 32'd0);

    // Stall test.
    drive(0);
    in_valid  = 1'b1;
    out_ready = 1'b0;
    #1;
    chk("R9 in_ready follows out_ready", 32'(c_in_ready), 32'd0);
    @(negedge clk);
    chk("R7 captured", 32'(q_out_valid), 32'd1);
    drive(6);
    #1;
    chk("R8 in_ready low in stall", 32'(q_in_ready), 32'd0);
    @(negedge clk);
    chk("R8 held valid", 32'(q_out_valid), 32'd1);
    chk("R8 held min", 32'(q_min), 32'h0A);
    chk("R8 held idx", 32'(q_idx), 32'd4);
    out_ready = 1'b1;
    #1;
    chk("R8 in_ready on release", 32'(q_in_ready), 32'd1);
    @(negedge clk);
    chk("R8 next set taken", 32'(q_out_valid), 32'd1);
    chk("R8 next min", 32'(q_min), 32'h01);
    chk("R8 next idx", 32'(q_idx), 32'd7);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R7 empty after take", 32'(q_out_valid), 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule